// File: doc/BRIEF.md
# Four-Way Miss Refill Engine with Dirty-Victim Castout

This block owns the tags, valid bits, dirty bits and replacement order of a four-way set-associative data cache, and it runs the miss path. A lookup request carries an address and a store flag. On a hit the way is made most-recently used, a store also marks it dirty, and a response comes back on the next cycle. On a miss a victim way is chosen: the lowest-numbered invalid way if there is one, otherwise the least-recently-used way. The victim is invalidated at once. If it held modified data, a castout of the old line is offered to memory first. The refill is then requested, and a four-beat burst is accepted. Only after the last beat is the line installed and made most-recently used.

The lookup port, the castout port, the refill request and the beat stream are valid/ready. Once the block raises `cast_valid` or `rd_valid`, it holds that signal and its address until the matching ready is seen. Upstream must hold `req_valid` and `req_addr` until `req_ready` is seen. The memory side may keep `beat_valid` low for any number of cycles. `remote_hold` is a plain level: while it is high, the refill request is not raised, which lets another cache's modified copy reach memory first. The data array lives outside the block and is steered by `cast_way`, `fill_way` and `beat_idx`.

Top module: `refill_engine`

## Requirements
- R1: An accepted request hits when its set has a valid way whose tag matches. The set is address bits [8:5] and the tag is bits [31:9]. One cycle after acceptance `resp_valid` pulses with `resp_hit`=1 and `resp_way` giving the hitting way.
- R2: A hit makes its way the most-recently used in the set. A hit with `req_store`=1 also marks that way modified.
- R3: On a miss the victim is the lowest-numbered invalid way. If no way is invalid, the victim is the least-recently-used way. After reset every way is invalid and the order from least to most recent is way 0, 1, 2, 3.
- R4: One cycle after a miss is accepted, `resp_valid` pulses with `resp_hit`=0 and `resp_way` naming the victim.
- R5: A victim that was valid and modified produces one castout: `cast_valid` with `cast_addr` = {old tag, set, 5'b0} and `cast_way` = the victim, held until `cast_ready`. A clean or invalid victim produces no castout.
- R6: The refill request is raised only after the castout handshake, if there is one, and only once `remote_hold` has been seen low at a clock edge. `rd_addr` is the miss address with bits [4:0] cleared, and it is held with `rd_valid` until `rd_ready`.
- R7: After the refill handshake `beat_ready` is high until four beats have been accepted. `beat_idx` counts 0 to 3 and `fill_way` names the victim. `fill_done` is high with the fourth accepted beat, and the line reads as valid only from the next cycle.
- R8: A line installed by a load is clean, and one installed by a store is modified. The installed way becomes most-recently used.
- R9: While a miss is in flight, a request to the same set is stalled. A request to another set is accepted only if it hits. No second miss is accepted.
- R10: Under reset `req_ready` is high and `resp_valid`, `cast_valid`, `rd_valid` and `beat_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request accepted |
| req_addr | input | 32 | Byte address of the lookup |
| req_store | input | 1 | Lookup is a store |
| resp_valid | output | 1 | Response pulse, one cycle after acceptance |
| resp_hit | output | 1 | 1 for a hit, 0 for a miss |
| resp_way | output | 2 | Hitting way or victim way |
| cast_valid | output | 1 | Castout of a modified victim offered |
| cast_ready | input | 1 | Memory takes the castout |
| cast_addr | output | 32 | Line address of the castout |
| cast_way | output | 2 | Way to read out for the castout |
| remote_hold | input | 1 | Delays the refill request while high |
| rd_valid | output | 1 | Refill burst request valid |
| rd_ready | input | 1 | Memory takes the refill request |
| rd_addr | output | 32 | Line address of the refill |
| beat_valid | input | 1 | Refill beat present |
| beat_ready | output | 1 | Block accepts refill beats |
| beat_idx | output | 2 | Index of the current beat in the line |
| fill_way | output | 2 | Way being filled |
| fill_done | output | 1 | Last beat accepted, line installed |

## Verification
The hardest case to reach from the ports is a hit to another set that is accepted while a dirty castout or a burst is still open. It comes with a modified victim evicted under a `remote_hold` stall and a store hit landing on the same clock as the final beat. The stimulus draws addresses from three sets and six tags, so sets fill up and dirty lines are evicted again and again. `cast_ready`, `rd_ready`, `beat_valid` and `remote_hold` are randomised so every wait state is stretched and crossed with in-flight lookups. A behavioural model keeps ages as time stamps and compares every output on every clock.

// File: rtl/rfe_pkg.sv
package rfe_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CAST,
    ST_WAIT,
    ST_ISSUE,
    ST_FILL
  } fsm_t;
endpackage

// File: rtl/rfe_lru.sv
module rfe_lru #(
  parameter int SETS = 16,
  parameter int WAYS = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int PAIRS = WAYS * (WAYS - 1) / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_en,
  input  logic [SET_W-1:0] a_set,
  input  logic [WAY_W-1:0] a_way,
  input  logic             b_en,
  input  logic [SET_W-1:0] b_set,
  input  logic [WAY_W-1:0] b_way,
  input  logic [SET_W-1:0] q_set,
  output logic [WAY_W-1:0] q_oldest
);
  // Pair bit (i,j), i<j: 1 when way i was used more recently than way j.
  logic [PAIRS-1:0] order_q [SETS];

  function automatic logic [PAIRS-1:0] make_newest(input logic [PAIRS-1:0] m,
                                                   input logic [WAY_W-1:0] w);
    logic [PAIRS-1:0] r;
    int p;
    r = m;
    p = 0;
    for (int i = 0; i < WAYS; i++) begin
      for (int j = i + 1; j < WAYS; j++) begin
        if (i == int'(w)) r[p] = 1'b1;
        else if (j == int'(w)) r[p] = 1'b0;
        p = p + 1;
      end
    end
    return r;
  endfunction

  function automatic logic [WAY_W-1:0] pick_oldest(input logic [PAIRS-1:0] m);
    logic [WAYS-1:0] cand;
    logic [WAY_W-1:0] r;
    int p;
    cand = '1;
    p = 0;
    for (int i = 0; i < WAYS; i++) begin
      for (int j = i + 1; j < WAYS; j++) begin
        if (m[p]) cand[i] = 1'b0;
        else cand[j] = 1'b0;
        p = p + 1;
      end
    end
    r = '0;
    for (int k = WAYS - 1; k >= 0; k--) begin
      if (cand[k]) r = WAY_W'(k);
    end
    return r;
  endfunction

  // Port a serves hits, port b serves refill completion; the controller keeps
  // them on different sets whenever both fire.
  for (genvar s = 0; s < SETS; s++) begin : g_set
    always_ff @(posedge clk) begin
      if (!rst_n) order_q[s] <= '0;
      else if (b_en && b_set == SET_W'(s)) order_q[s] <= make_newest(order_q[s], b_way);
      else if (a_en && a_set == SET_W'(s)) order_q[s] <= make_newest(order_q[s], a_way);
    end
  end

  assign q_oldest = pick_oldest(order_q[q_set]);
endmodule

// File: rtl/rfe_tags.sv
module rfe_tags #(
  parameter int SETS = 16,
  parameter int WAYS = 4,
  parameter int TAG_W = 23,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] q_set,
  output logic [TAG_W-1:0] q_tag [WAYS],
  output logic [WAYS-1:0]  q_valid,
  output logic [WAYS-1:0]  q_dirty,
  input  logic             mark_en,
  input  logic [WAY_W-1:0] mark_way,
  input  logic             kill_en,
  input  logic [WAY_W-1:0] kill_way,
  input  logic             inst_en,
  input  logic [SET_W-1:0] inst_set,
  input  logic [WAY_W-1:0] inst_way,
  input  logic [TAG_W-1:0] inst_tag,
  input  logic             inst_dirty
);
  logic [TAG_W-1:0] tag_q   [SETS][WAYS];
  logic [WAYS-1:0]  valid_q [SETS];
  logic [WAYS-1:0]  dirty_q [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic here_q, here_i, here_k;
      assign here_q = (q_set == SET_W'(s));
      assign here_i = inst_en && inst_set == SET_W'(s) && inst_way == WAY_W'(w);
      assign here_k = kill_en && here_q && kill_way == WAY_W'(w);

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          tag_q[s][w]   <= '0;
          valid_q[s][w] <= 1'b0;
          dirty_q[s][w] <= 1'b0;
        end else if (here_k) begin
          valid_q[s][w] <= 1'b0;
          dirty_q[s][w] <= 1'b0;
        end else if (here_i) begin
          tag_q[s][w]   <= inst_tag;
          valid_q[s][w] <= 1'b1;
          dirty_q[s][w] <= inst_dirty;
        end else if (mark_en && here_q && mark_way == WAY_W'(w)) begin
          dirty_q[s][w] <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    for (int w = 0; w < WAYS; w++) q_tag[w] = tag_q[q_set][w];
    q_valid = valid_q[q_set];
    q_dirty = dirty_q[q_set];
  end
endmodule

// File: rtl/rfe_ctrl.sv
module rfe_ctrl
  import rfe_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SETS = 16,
  parameter int WAYS = 4,
  parameter int BEATS = 4,
  parameter int BEAT_BYTES = 8,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int OFF_W = $clog2(BEATS * BEAT_BYTES),
  localparam int TAG_W = ADDR_W - OFF_W - SET_W,
  localparam int CNT_W = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_store,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic [WAY_W-1:0]  resp_way,
  output logic              cast_valid,
  input  logic              cast_ready,
  output logic [ADDR_W-1:0] cast_addr,
  output logic [WAY_W-1:0]  cast_way,
  input  logic              remote_hold,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              beat_valid,
  output logic              beat_ready,
  output logic [CNT_W-1:0]  beat_idx,
  output logic [WAY_W-1:0]  fill_way,
  output logic              fill_done,
  output logic [SET_W-1:0]  look_set,
  input  logic [TAG_W-1:0]  q_tag [WAYS],
  input  logic [WAYS-1:0]   q_valid,
  input  logic [WAYS-1:0]   q_dirty,
  input  logic [WAY_W-1:0]  lru_way,
  output logic              touch_en,
  output logic [WAY_W-1:0]  touch_way,
  output logic              mark_en,
  output logic              kill_en,
  output logic [WAY_W-1:0]  kill_way,
  output logic              inst_en,
  output logic [SET_W-1:0]  inst_set,
  output logic [WAY_W-1:0]  inst_way,
  output logic [TAG_W-1:0]  inst_tag,
  output logic              inst_dirty
);
  fsm_t             st_q;
  logic [SET_W-1:0] cur_set_q;
  logic [TAG_W-1:0] cur_tag_q, old_tag_q;
  logic [WAY_W-1:0] cur_way_q;
  logic             cur_store_q;
  logic [CNT_W-1:0] cnt_q;

  logic [TAG_W-1:0] look_tag;
  logic             hit, any_inv, acc, acc_miss;
  logic [WAY_W-1:0] hit_way, inv_way, victim;
  logic             unused_off;

  assign look_set   = req_addr[OFF_W +: SET_W];
  assign look_tag   = req_addr[ADDR_W-1 -: TAG_W];
  assign unused_off = ^req_addr[OFF_W-1:0];

  always_comb begin
    hit     = 1'b0;
    hit_way = '0;
    any_inv = 1'b0;
    inv_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (q_valid[w] && q_tag[w] == look_tag) begin
        hit     = 1'b1;
        hit_way = WAY_W'(w);
      end
    end
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!q_valid[w]) begin
        any_inv = 1'b1;
        inv_way = WAY_W'(w);
      end
    end
  end

  assign victim    = any_inv ? inv_way : lru_way;
  assign req_ready = (st_q == ST_IDLE) || (look_set != cur_set_q && hit);
  assign acc       = req_valid && req_ready;
  assign acc_miss  = acc && !hit;

  assign touch_en  = acc && hit;
  assign touch_way = hit_way;
  assign mark_en   = acc && hit && req_store;
  assign kill_en   = acc_miss;
  assign kill_way  = victim;

  assign fill_done  = (st_q == ST_FILL) && beat_valid && cnt_q == CNT_W'(BEATS - 1);
  assign inst_en    = fill_done;
  assign inst_set   = cur_set_q;
  assign inst_way   = cur_way_q;
  assign inst_tag   = cur_tag_q;
  assign inst_dirty = cur_store_q;

  assign cast_valid = (st_q == ST_CAST);
  assign cast_addr  = {old_tag_q, cur_set_q, OFF_W'(0)};
  assign cast_way   = cur_way_q;
  assign rd_valid   = (st_q == ST_ISSUE);
  assign rd_addr    = {cur_tag_q, cur_set_q, OFF_W'(0)};
  assign beat_ready = (st_q == ST_FILL);
  assign beat_idx   = cnt_q;
  assign fill_way   = cur_way_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      cur_set_q   <= '0;
      cur_tag_q   <= '0;
      old_tag_q   <= '0;
      cur_way_q   <= '0;
      cur_store_q <= 1'b0;
      cnt_q       <= '0;
      resp_valid  <= 1'b0;
      resp_hit    <= 1'b0;
      resp_way    <= '0;
    end else begin
      resp_valid <= acc;
      if (acc) begin
        resp_hit <= hit;
        resp_way <= hit ? hit_way : victim;
      end
      case (st_q)
        ST_IDLE: if (acc_miss) begin
          cur_set_q   <= look_set;
          cur_tag_q   <= look_tag;
          old_tag_q   <= q_tag[victim];
          cur_way_q   <= victim;
          cur_store_q <= req_store;
          st_q        <= (q_valid[victim] && q_dirty[victim]) ? ST_CAST : ST_WAIT;
        end
        ST_CAST:  if (cast_ready) st_q <= ST_WAIT;
        ST_WAIT:  if (!remote_hold) st_q <= ST_ISSUE;
        ST_ISSUE: if (rd_ready) begin
          st_q  <= ST_FILL;
          cnt_q <= '0;
        end
        ST_FILL: if (beat_valid) begin
          cnt_q <= cnt_q + 1'b1;
          if (fill_done) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/refill_engine.sv
module refill_engine #(
  parameter int ADDR_W = 32,
  parameter int SETS = 16,
  parameter int WAYS = 4,
  parameter int BEATS = 4,
  parameter int BEAT_BYTES = 8,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int OFF_W = $clog2(BEATS * BEAT_BYTES),
  localparam int TAG_W = ADDR_W - OFF_W - SET_W,
  localparam int CNT_W = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_store,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic [WAY_W-1:0]  resp_way,
  output logic              cast_valid,
  input  logic              cast_ready,
  output logic [ADDR_W-1:0] cast_addr,
  output logic [WAY_W-1:0]  cast_way,
  input  logic              remote_hold,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              beat_valid,
  output logic              beat_ready,
  output logic [CNT_W-1:0]  beat_idx,
  output logic [WAY_W-1:0]  fill_way,
  output logic              fill_done
);
  logic [SET_W-1:0] look_set, inst_set;
  logic [TAG_W-1:0] q_tag [WAYS];
  logic [WAYS-1:0]  q_valid, q_dirty;
  logic [WAY_W-1:0] lru_way, touch_way, kill_way, inst_way;
  logic [TAG_W-1:0] inst_tag;
  logic             touch_en, mark_en, kill_en, inst_en, inst_dirty;

  rfe_ctrl #(
    .ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS), .BEATS(BEATS), .BEAT_BYTES(BEAT_BYTES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_store(req_store),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_way(resp_way),
    .cast_valid(cast_valid), .cast_ready(cast_ready), .cast_addr(cast_addr), .cast_way(cast_way),
    .remote_hold(remote_hold),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .beat_valid(beat_valid), .beat_ready(beat_ready), .beat_idx(beat_idx),
    .fill_way(fill_way), .fill_done(fill_done),
    .look_set(look_set), .q_tag(q_tag), .q_valid(q_valid), .q_dirty(q_dirty),
    .lru_way(lru_way), .touch_en(touch_en), .touch_way(touch_way),
    .mark_en(mark_en), .kill_en(kill_en), .kill_way(kill_way),
    .inst_en(inst_en), .inst_set(inst_set), .inst_way(inst_way),
    .inst_tag(inst_tag), .inst_dirty(inst_dirty)
  );

  rfe_tags #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .q_set(look_set), .q_tag(q_tag), .q_valid(q_valid), .q_dirty(q_dirty),
    .mark_en(mark_en), .mark_way(touch_way),
    .kill_en(kill_en), .kill_way(kill_way),
    .inst_en(inst_en), .inst_set(inst_set), .inst_way(inst_way),
    .inst_tag(inst_tag), .inst_dirty(inst_dirty)
  );

  rfe_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
    .clk(clk), .rst_n(rst_n),
    .a_en(touch_en), .a_set(look_set), .a_way(touch_way),
    .b_en(inst_en), .b_set(inst_set), .b_way(inst_way),
    .q_set(look_set), .q_oldest(lru_way)
  );
endmodule

// File: rtl/refill_engine_chk.sv
module refill_engine_chk #(
  parameter int ADDR_W = 32,
  parameter int SETS = 16,
  parameter int BEATS = 4,
  parameter int BEAT_BYTES = 8,
  localparam int SET_W = $clog2(SETS),
  localparam int OFF_W = $clog2(BEATS * BEAT_BYTES),
  localparam int CNT_W = $clog2(BEATS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              resp_valid,
  input logic              cast_valid,
  input logic              cast_ready,
  input logic [ADDR_W-1:0] cast_addr,
  input logic              remote_hold,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              beat_valid,
  input logic              beat_ready,
  input logic [CNT_W-1:0]  beat_idx,
  input logic              fill_done
);
  assert_resp_follows_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(req_valid && req_ready));

  assert_cast_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cast_valid && !cast_ready |=> cast_valid && $stable(cast_addr));

  assert_rd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));

  assert_rd_after_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> !$past(remote_hold));

  assert_phase_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cast_valid, rd_valid, beat_ready}));

  assert_beat_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_ready && !fill_done |=> beat_ready && beat_idx == $past(beat_idx) + 1'b1);

  assert_last_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> !beat_ready);

  assert_no_same_set_cast_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cast_valid && req_valid && req_ready |-> req_addr[OFF_W +: SET_W] != cast_addr[OFF_W +: SET_W]);

  assert_no_same_set_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid || beat_ready) && req_valid && req_ready |-> req_addr[OFF_W +: SET_W] != rd_addr[OFF_W +: SET_W]);
endmodule

bind refill_engine refill_engine_chk #(
  .ADDR_W(ADDR_W), .SETS(SETS), .BEATS(BEATS), .BEAT_BYTES(BEAT_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
  .resp_valid(resp_valid), .cast_valid(cast_valid), .cast_ready(cast_ready), .cast_addr(cast_addr),
  .remote_hold(remote_hold), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
  .beat_valid(beat_valid), .beat_ready(beat_ready), .beat_idx(beat_idx), .fill_done(fill_done)
);

// File: tb/refill_engine_test.sv
module refill_engine_test;
  localparam int SETS = 16;
  localparam int WAYS = 4;
  localparam int CYCLES = 4000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_store = 1'b0;
  logic [31:0] req_addr = '0;
  logic cast_ready = 1'b0, remote_hold = 1'b0, rd_ready = 1'b0, beat_valid = 1'b0;
  logic req_ready, resp_valid, resp_hit, cast_valid, rd_valid, beat_ready, fill_done;
  logic [1:0] resp_way, cast_way, beat_idx, fill_way;
  logic [31:0] cast_addr, rd_addr;

  int checks = 0;
  int errors = 0;

  // Reference state: ages are time stamps, smallest stamp is least recent.
  int  m_tag [SETS][WAYS];
  bit  m_val [SETS][WAYS];
  bit  m_dirty [SETS][WAYS];
  int  m_stamp [SETS][WAYS];
  int  stamp_ctr;
  int  m_st;           // 0 idle, 1 castout, 2 wait, 3 issue, 4 fill
  int  c_set, c_tag, c_way, c_old, c_cnt;
  bit  c_store;
  bit  e_rv, e_rh;
  int  e_rw;

  always #2 clk = ~clk;

  refill_engine uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_store(req_store), .resp_valid(resp_valid),
    .resp_hit(resp_hit), .resp_way(resp_way), .cast_valid(cast_valid),
    .cast_ready(cast_ready), .cast_addr(cast_addr), .cast_way(cast_way),
    .remote_hold(remote_hold), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_addr(rd_addr), .beat_valid(beat_valid), .beat_ready(beat_ready),
    .beat_idx(beat_idx), .fill_way(fill_way), .fill_done(fill_done)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit pend;
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        m_val[s][w] = 0; m_dirty[s][w] = 0; m_tag[s][w] = 0; m_stamp[s][w] = w;
      end
    stamp_ctr = WAYS;
    m_st = 0; c_set = 0; c_tag = 0; c_way = 0; c_old = 0; c_cnt = 0; c_store = 0;
    e_rv = 0; e_rh = 0; e_rw = 0;
    pend = 0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 reset req_ready", 64'(req_ready), 64'd1);
    check("R10 reset resp_valid", 64'(resp_valid), 64'd0);
    check("R10 reset cast_valid", 64'(cast_valid), 64'd0);
    check("R10 reset rd_valid", 64'(rd_valid), 64'd0);
    check("R10 reset beat_ready", 64'(beat_ready), 64'd0);
    rst_n = 1'b1;

    for (int cyc = 0; cyc < CYCLES; cyc++) begin
      int set, tag, hw, vic;
      bit hit, rdy;
      @(negedge clk);
      if (!pend && ($urandom % 2 == 0)) begin
        pend = 1;
        req_addr = ((32'($urandom % 6)) << 9) | ((32'($urandom % 3)) << 5) | 32'($urandom % 32);
        req_store = ($urandom % 5 < 2);
      end
      req_valid   = pend;
      cast_ready  = ($urandom % 3 != 0);
      rd_ready    = ($urandom % 3 != 0);
      beat_valid  = ($urandom % 4 != 0);
      remote_hold = ($urandom % 3 == 0);
      #1;

      set = int'(req_addr[8:5]);
      tag = int'(req_addr[31:9]);
      hit = 0; hw = 0;
      for (int w = 0; w < WAYS; w++)
        if (m_val[set][w] && m_tag[set][w] == tag) begin hit = 1; hw = w; end
      vic = -1;
      for (int w = 0; w < WAYS; w++) if (vic < 0 && !m_val[set][w]) vic = w;
      if (vic < 0) begin
        vic = 0;
        for (int w = 1; w < WAYS; w++) if (m_stamp[set][w] < m_stamp[set][vic]) vic = w;
      end
      rdy = (m_st == 0) || (set != c_set && hit);

      check("R9 req_ready", 64'(req_ready), 64'(rdy));
      check("R1 R4 resp_valid", 64'(resp_valid), 64'(e_rv));
      if (e_rv) begin
        check(e_rh ? "R1 resp_hit" : "R4 resp_hit", 64'(resp_hit), 64'(e_rh));
        check(e_rh ? "R1 R2 resp_way" : "R3 R4 victim way", 64'(resp_way), 64'(e_rw));
      end
      check("R5 R2 R8 cast_valid", 64'(cast_valid), 64'(m_st == 1));
      if (m_st == 1) begin
        check("R5 cast_addr", 64'(cast_addr), 64'((c_old << 9) | (c_set << 5)));
        check("R5 cast_way", 64'(cast_way), 64'(c_way));
      end
      check("R6 rd_valid", 64'(rd_valid), 64'(m_st == 3));
      if (m_st == 3) check("R6 rd_addr", 64'(rd_addr), 64'((c_tag << 9) | (c_set << 5)));
      check("R7 beat_ready", 64'(beat_ready), 64'(m_st == 4));
      check("R7 fill_done", 64'(fill_done), 64'(m_st == 4 && beat_valid && c_cnt == 3));
      if (m_st == 4) begin
        check("R7 beat_idx", 64'(beat_idx), 64'(c_cnt));
        check("R7 fill_way", 64'(fill_way), 64'(c_way));
      end

      // Advance the reference model by one clock.
      e_rv = 0;
      case (m_st)
        1: if (cast_ready) m_st = 2;
        2: if (!remote_hold) m_st = 3;
        3: if (rd_ready) begin m_st = 4; c_cnt = 0; end
        4: if (beat_valid) begin
          if (c_cnt == 3) begin
            m_tag[c_set][c_way] = c_tag;
            m_val[c_set][c_way] = 1;
            m_dirty[c_set][c_way] = c_store;
            m_stamp[c_set][c_way] = stamp_ctr++;
            m_st = 0;
          end
          c_cnt++;
        end
        default: ;
      endcase
      if (pend && rdy) begin
        pend = 0;
        e_rv = 1;
        e_rh = hit;
        if (hit) begin
          e_rw = hw;
          m_stamp[set][hw] = stamp_ctr++;
          if (req_store) m_dirty[set][hw] = 1;
        end else begin
          e_rw = vic;
          c_set = set; c_tag = tag; c_way = vic; c_store = req_store;
          c_old = m_tag[set][vic];
          m_st = (m_val[set][vic] && m_dirty[set][vic]) ? 1 : 2;
          m_val[set][vic] = 0;
          m_dirty[set][vic] = 0;
        end
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule